// File: doc/BRIEF.md
# NAND Chunk Hamming Code Generator

This block builds a single-error-correcting Hamming code, three bytes long, over every 256-byte chunk that passes through a NAND controller's data window. It does not matter whether the host is reading from the flash or writing to it. Each byte that crosses the window is folded into two sets of parity terms:

- line parities, split by the bits of the byte's index inside the chunk;
- column parities, split by each data bit's position inside the byte.

Host software arms the generator with a single control write. It then moves one chunk of data and reads the finished code back. It can read the three code bytes one by one, or read one 32-bit word that also carries the controller's status byte. Syndrome decoding and correction are left to host software.

The code uses the common software Hamming layout for 256-byte blocks. The line-parity byte for index bits 0 to 3 is the first byte stored on flash. The line-parity byte for index bits 4 to 7 is second, and the column byte is third. The register readback order is not the same as this stored order.

Top module: `nand_page_ecc`

## Requirements
- R1: After reset, the enable and invert bits are 0 and all parity terms and the byte index are 0. The outputs are therefore `ecc_lo`=0x00, `ecc_hi`=0x00, `ecc_col`=0x03 and `chunk_done`=0.
- R2: A control write loads `ctl_wdata[0]` as enable and `ctl_wdata[2]` as invert. `ctl_wdata[1]` requests a clear and is never stored. `ctl_rdata` reads {5'b0, invert, 1'b0, enable}.
- R3: A control write with bit 1 set zeroes every parity term and the byte index in the next cycle. A window transfer in that same cycle is not counted.
- R4: While enable is 0, window transfers leave the code and the byte index unchanged.
- R5: Each counted byte is XOR-folded into line term 2k+b, where b is bit k of its index, for k = 0..7. Line terms 0..7 appear in `ecc_hi` bits 0..7, and line terms 8..15 appear in `ecc_lo` bits 0..7. The index then advances by one.
- R6: Each data bit at position j is XOR-folded into column term 2m+c, where c is bit m of j, for m = 0..2. Column terms 0..5 appear in `ecc_col` bits 2..7.
- R7: With invert set, every line and column term is presented inverted, so a chunk of 256 bytes of 0xFF reads FF FF FF.
- R8: After 256 counted bytes, `chunk_done` is 1 and the code stays frozen until the next clear.
- R9: `ecc_word` is {`ecc_col`, `ecc_hi`, `ecc_lo`, `sts_byte`}, with `sts_byte` in bits 7:0.
- R10: Bits 1:0 of `ecc_col` always read 1, whatever the invert setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_xfer | input | 1 | One byte crosses the data window this cycle (read or write) |
| win_byte | input | 8 | The byte crossing the window |
| ctl_wr | input | 1 | Write strobe for the code control register |
| ctl_wdata | input | 3 | Control data: bit0 enable, bit1 clear, bit2 invert |
| sts_byte | input | 8 | Controller status byte merged into the word readback |
| ecc_lo | output | 8 | Line-parity byte for index bits 4..7 |
| ecc_hi | output | 8 | Line-parity byte for index bits 0..3 |
| ecc_col | output | 8 | Column-parity byte |
| ecc_word | output | 32 | Status and code in one aligned word |
| ctl_rdata | output | 8 | Control register readback |
| chunk_done | output | 1 | 256 bytes have been counted since the last clear |

## Verification
The generator is tried with the following chunks:

- A chunk that is all 0xFF in inverted mode. This separates correct inversion from missing or partial inversion.
- A chunk that is all zero except for one bit, in raw mode. This yields hand-derived code bytes, so it exposes any swapped line pair, any wrong index bit and any misplaced column term.
- An index-dependent byte pattern, compared against a per-bit model of the parity equations.
- Traffic sent while the generator is disabled, and traffic that runs past 256 bytes. These separate gating from freezing.
- A clear that arrives in the same cycle as a transfer, followed by one byte. This shows whether the byte index truly restarts at zero.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
  localparam int IDX_W  = 8;
  localparam int BYTE_W = 8;
  localparam int POS_W  = 3;
  localparam int LINE_W = 2 * IDX_W;
  localparam int COL_W  = 2 * POS_W;
  localparam int CNT_W  = IDX_W + 1;
  localparam int CHUNK  = 1 << IDX_W;
  localparam int CTL_W  = 3;

  // parity of a whole byte
  function automatic logic byte_par(input logic [BYTE_W-1:0] d);
    return ^d;
  endfunction

  // line contribution: parity goes to term 2k+idx[k]
  function automatic logic [LINE_W-1:0] line_terms(input logic [IDX_W-1:0] idx,
                                                   input logic p);
    logic [LINE_W-1:0] t;
    t = '0;
    for (int k = 0; k < IDX_W; k++) begin
      t[2*k + int'(idx[k])] = p;
    end
    return t;
  endfunction

  // column contribution: bit j goes to term 2m+j[m]
  function automatic logic [COL_W-1:0] col_terms(input logic [BYTE_W-1:0] d);
    logic [COL_W-1:0] t;
    logic [POS_W-1:0] j;
    t = '0;
    for (int b = 0; b < BYTE_W; b++) begin
      j = POS_W'(b);
      for (int m = 0; m < POS_W; m++) begin
        t[2*m + int'(j[m])] = t[2*m + int'(j[m])] ^ d[b];
      end
    end
    return t;
  endfunction
endpackage

// File: rtl/nand_ecc_ctl.sv
module nand_ecc_ctl
  import nand_ecc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic             en_q,
  output logic             inv_q,
  output logic             clr_pulse
);
  assign clr_pulse = ctl_wr & ctl_wdata[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      inv_q <= 1'b0;
    end else if (ctl_wr) begin
      en_q  <= ctl_wdata[0];
      inv_q <= ctl_wdata[2];
    end
  end
endmodule

// File: rtl/nand_ecc_seq.sv
module nand_ecc_seq
  import nand_ecc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             win_xfer,
  input  logic             en_q,
  input  logic             clr_pulse,
  output logic             acc_fire,
  output logic             chunk_full,
  output logic [CNT_W-1:0] cnt_q
);
  assign chunk_full = cnt_q[IDX_W];
  assign acc_fire   = win_xfer & en_q & ~chunk_full & ~clr_pulse;

  always_ff @(posedge clk) begin
    if (!rst_n || clr_pulse) cnt_q <= '0;
    else if (acc_fire)       cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/nand_ecc_line_acc.sv
module nand_ecc_line_acc
  import nand_ecc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_pulse,
  input  logic              acc_fire,
  input  logic [IDX_W-1:0]  idx,
  input  logic [BYTE_W-1:0] data,
  output logic [LINE_W-1:0] line_q
);
  logic [LINE_W-1:0] contrib;
  assign contrib = line_terms(idx, byte_par(data));

  for (genvar k = 0; k < IDX_W; k++) begin : g_pair
    logic even_q, odd_q;
    always_ff @(posedge clk) begin
      if (!rst_n || clr_pulse) begin
        even_q <= 1'b0;
        odd_q  <= 1'b0;
      end else if (acc_fire) begin
        even_q <= even_q ^ contrib[2*k];
        odd_q  <= odd_q  ^ contrib[2*k+1];
      end
    end
    assign line_q[2*k]   = even_q;
    assign line_q[2*k+1] = odd_q;
  end
endmodule

// File: rtl/nand_ecc_col_acc.sv
module nand_ecc_col_acc
  import nand_ecc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_pulse,
  input  logic              acc_fire,
  input  logic [BYTE_W-1:0] data,
  output logic [COL_W-1:0]  col_q
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr_pulse) col_q <= '0;
    else if (acc_fire)       col_q <= col_q ^ col_terms(data);
  end
endmodule

// File: rtl/nand_ecc_readback.sv
module nand_ecc_readback
  import nand_ecc_pkg::*;
(
  input  logic              inv_q,
  input  logic              en_q,
  input  logic [LINE_W-1:0] line_q,
  input  logic [COL_W-1:0]  col_q,
  input  logic [7:0]        sts_byte,
  output logic [7:0]        ecc_lo,
  output logic [7:0]        ecc_hi,
  output logic [7:0]        ecc_col,
  output logic [31:0]       ecc_word,
  output logic [7:0]        ctl_rdata
);
  logic [LINE_W-1:0] line_v;
  logic [COL_W-1:0]  col_v;

  assign line_v    = line_q ^ {LINE_W{inv_q}};
  assign col_v     = col_q  ^ {COL_W{inv_q}};
  assign ecc_hi    = line_v[IDX_W-1:0];
  assign ecc_lo    = line_v[LINE_W-1:IDX_W];
  assign ecc_col   = {col_v, 2'b11};
  assign ecc_word  = {ecc_col, ecc_hi, ecc_lo, sts_byte};
  assign ctl_rdata = {5'b0, inv_q, 1'b0, en_q};
endmodule

// File: rtl/nand_page_ecc.sv
module nand_page_ecc
  import nand_ecc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             win_xfer,
  input  logic [7:0]       win_byte,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic [7:0]       sts_byte,
  output logic [7:0]       ecc_lo,
  output logic [7:0]       ecc_hi,
  output logic [7:0]       ecc_col,
  output logic [31:0]      ecc_word,
  output logic [7:0]       ctl_rdata,
  output logic             chunk_done
);
  logic              en_q, inv_q, clr_pulse, acc_fire, chunk_full;
  logic [CNT_W-1:0]  cnt_q;
  logic [LINE_W-1:0] line_q;
  logic [COL_W-1:0]  col_q;

  nand_ecc_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .en_q(en_q), .inv_q(inv_q), .clr_pulse(clr_pulse)
  );

  nand_ecc_seq u_seq (
    .clk(clk), .rst_n(rst_n), .win_xfer(win_xfer), .en_q(en_q),
    .clr_pulse(clr_pulse), .acc_fire(acc_fire), .chunk_full(chunk_full),
    .cnt_q(cnt_q)
  );

  nand_ecc_line_acc u_line (
    .clk(clk), .rst_n(rst_n), .clr_pulse(clr_pulse), .acc_fire(acc_fire),
    .idx(cnt_q[IDX_W-1:0]), .data(win_byte), .line_q(line_q)
  );

  nand_ecc_col_acc u_col (
    .clk(clk), .rst_n(rst_n), .clr_pulse(clr_pulse), .acc_fire(acc_fire),
    .data(win_byte), .col_q(col_q)
  );

  nand_ecc_readback u_rb (
    .inv_q(inv_q), .en_q(en_q), .line_q(line_q), .col_q(col_q),
    .sts_byte(sts_byte), .ecc_lo(ecc_lo), .ecc_hi(ecc_hi), .ecc_col(ecc_col),
    .ecc_word(ecc_word), .ctl_rdata(ctl_rdata)
  );

  assign chunk_done = chunk_full;
endmodule

// File: rtl/nand_page_ecc_chk.sv
module nand_page_ecc_chk
  import nand_ecc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              clr_pulse,
  input logic              acc_fire,
  input logic              en_q,
  input logic              win_xfer,
  input logic              ctl_wr,
  input logic [CTL_W-1:0]  ctl_wdata,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [LINE_W-1:0] line_q,
  input logic [COL_W-1:0]  col_q,
  input logic [7:0]        ecc_col,
  input logic              chunk_done
);
  assert_enable_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> (en_q == $past(ctl_wdata[0])));

  assert_clear_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |=> (cnt_q == '0 && line_q == '0 && col_q == '0));

  assert_clear_beats_xfer_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_pulse && win_xfer) |-> !acc_fire);

  assert_disabled_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !clr_pulse) |=> ($stable(line_q) && $stable(col_q) && $stable(cnt_q)));

  assert_index_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire |=> (cnt_q == $past(cnt_q) + 1'b1));

  assert_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (chunk_done && !clr_pulse) |=> ($stable(line_q) && $stable(col_q) && chunk_done));

  assert_index_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(CHUNK));

  assert_col_low_ones_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ecc_col[1:0] == 2'b11);
endmodule

bind nand_page_ecc nand_page_ecc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .clr_pulse(clr_pulse), .acc_fire(acc_fire),
  .en_q(en_q), .win_xfer(win_xfer), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
  .cnt_q(cnt_q), .line_q(line_q), .col_q(col_q), .ecc_col(ecc_col),
  .chunk_done(chunk_done)
);

// File: tb/sim_nand_page_ecc.sv
module sim_nand_page_ecc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        win_xfer = 1'b0;
  logic [7:0]  win_byte = 8'h00;
  logic        ctl_wr = 1'b0;
  logic [2:0]  ctl_wdata = 3'b000;
  logic [7:0]  sts_byte = 8'hA3;
  logic [7:0]  ecc_lo, ecc_hi, ecc_col, ctl_rdata;
  logic [31:0] ecc_word;
  logic        chunk_done;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // bench-side model state
  logic [15:0] m_line = '0;
  logic [5:0]  m_col = '0;
  int          m_cnt = 0;
  bit          m_en = 1'b0;
  bit          m_inv = 1'b0;

  always #5 clk = ~clk;

  nand_page_ecc u0 (
    .clk(clk), .rst_n(rst_n), .win_xfer(win_xfer), .win_byte(win_byte),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .sts_byte(sts_byte),
    .ecc_lo(ecc_lo), .ecc_hi(ecc_hi), .ecc_col(ecc_col), .ecc_word(ecc_word),
    .ctl_rdata(ctl_rdata), .chunk_done(chunk_done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-bit restatement of the parity equations
  task automatic model_byte(input logic [7:0] d);
    logic [7:0] idx;
    if (!m_en || m_cnt >= 256) return;
    idx = 8'(m_cnt);
    for (int b = 0; b < 8; b++) begin
      if (d[b]) begin
        for (int k = 0; k < 8; k++) m_line[2*k + (idx[k] ? 1 : 0)] ^= 1'b1;
        for (int m = 0; m < 3; m++) m_col[2*m + ((b >> m) & 1)] ^= 1'b1;
      end
    end
    m_cnt++;
  endtask

  function automatic logic [23:0] model_code();
    logic [7:0] hi, lo, col;
    hi  = m_line[7:0]  ^ {8{m_inv}};
    lo  = m_line[15:8] ^ {8{m_inv}};
    col = {m_col ^ {6{m_inv}}, 2'b11};
    return {col, hi, lo};
  endfunction

  task automatic ctl_write(input logic [2:0] v);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_wdata = v;
    @(negedge clk);
    ctl_wr = 1'b0;
    m_en = v[0]; m_inv = v[2];
    if (v[1]) begin m_line = '0; m_col = '0; m_cnt = 0; end
  endtask

  task automatic send(input logic [7:0] d);
    @(negedge clk);
    win_xfer = 1'b1; win_byte = d;
    @(negedge clk);
    win_xfer = 1'b0;
    model_byte(d);
  endtask

  task automatic check_code(input string req);
    check(req, {8'h00, ecc_col, ecc_hi, ecc_lo}, {8'h00, model_code()});
  endtask

  task automatic t_reset();
    check("R1 lo", ecc_lo, 8'h00);
    check("R1 hi", ecc_hi, 8'h00);
    check("R1 col", ecc_col, 8'h03);
    check("R1 done", chunk_done, 1'b0);
    check("R1 ctl", ctl_rdata, 8'h00);
  endtask

  task automatic t_ctl_readback();
    ctl_write(3'b111);
    check("R2 ctl after 0x07", ctl_rdata, 8'h05);
    ctl_write(3'b010);
    check("R2 ctl after 0x02", ctl_rdata, 8'h00);
  endtask

  task automatic t_erased();
    ctl_write(3'b111);
    for (int i = 0; i < 256; i++) send(8'hFF);
    check("R7 erased code", {8'h00, ecc_col, ecc_hi, ecc_lo}, 32'h00FFFFFF);
    check("R8 done after 256", chunk_done, 1'b1);
  endtask

  task automatic t_single_bit();
    ctl_write(3'b011);
    for (int i = 0; i < 256; i++) send(i == 8'hA5 ? 8'h10 : 8'h00);
    check("R5 hi single bit", ecc_hi, 8'h66);
    check("R5 lo single bit", ecc_lo, 8'h99);
    check("R6 col single bit", ecc_col, 8'h97);
  endtask

  task automatic t_pattern();
    ctl_write(3'b111);
    for (int i = 0; i < 256; i++) send(8'((i * 37 + 11) ^ (i >> 3)));
    check_code("R5 R6 R7 pattern");
  endtask

  task automatic t_disabled();
    ctl_write(3'b110);
    for (int i = 0; i < 5; i++) send(8'h3C);
    check("R4 no count while disabled", {8'h00, ecc_col, ecc_hi, ecc_lo}, 32'h00FFFFFF);
    ctl_write(3'b111);
    for (int i = 0; i < 10; i++) send(8'(i * 29 + 1));
    ctl_write(3'b100);
    for (int i = 0; i < 5; i++) send(8'h81);
    check_code("R4 hold mid chunk");
    check("R4 not done", chunk_done, 1'b0);
    ctl_write(3'b101);
    send(8'h40);
    check_code("R4 resume index");
  endtask

  task automatic t_freeze();
    ctl_write(3'b011);
    for (int i = 0; i < 256; i++) send(8'(i ^ 8'h5A));
    for (int i = 0; i < 44; i++) send(8'h01);
    check_code("R8 frozen after 256");
    check("R8 done flag", chunk_done, 1'b1);
    check("R10 raw col low bits", ecc_col[1:0], 2'b11);
  endtask

  task automatic t_collide();
    ctl_write(3'b011);
    for (int i = 0; i < 3; i++) send(8'h77);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_wdata = 3'b011; win_xfer = 1'b1; win_byte = 8'hFF;
    @(negedge clk);
    ctl_wr = 1'b0; win_xfer = 1'b0;
    m_line = '0; m_col = '0; m_cnt = 0; m_en = 1'b1; m_inv = 1'b0;
    check("R3 cleared code", {8'h00, ecc_col, ecc_hi, ecc_lo}, 32'h00030000);
    send(8'h01);
    check("R3 index restarts hi", ecc_hi, 8'h55);
    check("R3 index restarts lo", ecc_lo, 8'h55);
    check("R6 col bit0", ecc_col, 8'h57);
  endtask

  task automatic t_word();
    sts_byte = 8'hC6;
    #1;
    check("R9 word layout", ecc_word, {ecc_col, ecc_hi, ecc_lo, 8'hC6});
    check("R9 word value", ecc_word, {8'h57, 8'h55, 8'h55, 8'hC6});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctl_readback();
    t_erased();
    t_single_bit();
    t_pattern();
    t_disabled();
    t_freeze();
    t_collide();
    t_word();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule